// File: doc/BRIEF.md
# Pseudo-SRAM Burst Stall and Latency Sequencer

This block models, on the device side, the stall output of a burst-capable pseudo-SRAM and the timing of its burst beats. A chip select and an address strobe start an access. The sequencer then holds the stall output active through the initial access latency and releases it in the cycle in which the first beat is valid. After that, one beat follows on every clock edge. At the last column of a row the stall output goes active again for a fixed number of cycles, and the burst resumes at column zero.

In variable-latency mode, a read that starts while the internal refresh-busy input is high is held for as long as the refresh stays busy. Fixed-latency mode and writes never see this extension. When the configuration selects asynchronous operation, the stall output follows the chip select and carries no timing meaning, and no beats are produced. The stall output is registered on the rising clock edge, and its active level is a parameter. The memory array, refresh scheduling and the open-drain driver are outside this block.

Top module: `psram_wait_gen`

## Requirements
- R1: While reset is asserted, and after its release with no access started, `stall_o` sits at its inactive level and `beat_vld_o` is 0.
- R2: With `cfg_sync_burst`=1, an edge that samples `cs_n`=0 and `addr_lat_n`=0 starts an access. After that edge `stall_o` is active and `beat_vld_o` is 0, and both stay so until the first beat.
- R3: Without a refresh collision, `beat_vld_o` first goes to 1 after the LATENCY-th edge following the start edge, with `stall_o` inactive in that same cycle and `beat_col_o` equal to the `addr_col` sampled at the start edge.
- R4: While `cs_n`=0 and `addr_lat_n`=1, beats continue on every following edge and the column goes up by one each time.
- R5: With `cfg_fixed_lat`=0 and `wr_en`=0, if `refresh_busy` is 1 at the start edge, each later edge at which it is still 1 adds one cycle of stall. A refresh that rises only after the start edge adds nothing.
- R6: With `cfg_fixed_lat`=1, `refresh_busy` has no effect on the latency.
- R7: A write (`wr_en`=1 at the start edge) is never extended by `refresh_busy`.
- R8: After a beat on column 2^COL_BITS-1, `stall_o` is active and `beat_vld_o` is 0 for ROW_STALL cycles. The next beat is on column 0.
- R9: With `cfg_sync_burst`=0, `stall_o` is active after every edge that samples `cs_n`=0, `beat_vld_o` stays 0, and `addr_lat_n` is ignored.
- R10: After any edge that samples `cs_n`=1, `stall_o` is inactive and `beat_vld_o` is 0. Staying selected afterwards without a new strobe keeps the block idle.
- R11: With WAIT_ACTIVE_HIGH=1 the active level of `stall_o` is 1; with 0 it is 0.
- R12: A strobe during the latency or during the beats restarts the access from the newly sampled column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| addr_lat_n | input | 1 | Address strobe, active low; starts an access |
| wr_en | input | 1 | 1 = write access, 0 = read access, sampled at start |
| addr_col | input | COL_BITS | Starting column within the row |
| cfg_sync_burst | input | 1 | 1 = synchronous burst operation, 0 = asynchronous |
| cfg_fixed_lat | input | 1 | 1 = fixed initial latency, 0 = variable |
| refresh_busy | input | 1 | Internal refresh in progress |
| stall_o | output | 1 | Stall indication, active level set by WAIT_ACTIVE_HIGH |
| beat_vld_o | output | 1 | One per valid burst beat |
| beat_col_o | output | COL_BITS | Column of the current beat |

## Verification
The bench builds the block with LATENCY=3, COL_BITS=3, ROW_STALL=2 and WAIT_ACTIVE_HIGH=0. Eight-column rows let a short burst cross a row end, and often, so the two-cycle row stall and the wrap to column zero can be checked. The active-low stall level exercises the polarity parameter. A three-cycle base latency leaves room to set a refresh collision apart from a refresh that rises mid-latency, and to abort or restart an access partway through its latency.

// File: rtl/psram_wait_pkg.sv
package psram_wait_pkg;
  typedef enum logic [1:0] {
    PH_IDLE     = 2'd0,
    PH_LATENCY  = 2'd1,
    PH_BEAT     = 2'd2,
    PH_ROWSTALL = 2'd3
  } phase_e;
endpackage

// File: rtl/psram_rst_sync.sv
module psram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/psram_dwell_ctr.sv
module psram_dwell_ctr #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load)                     cnt_n = load_val;
    else if (dec && cnt_q != '0)  cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign expired = (cnt_q == '0);

  // R3: the sequencer never asks for a count below zero
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> !expired);
endmodule

// File: rtl/psram_col_tracker.sv
module psram_col_tracker #(
  parameter int COL_BITS = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [COL_BITS-1:0] load_col,
  input  logic                inc,
  output logic [COL_BITS-1:0] col,
  output logic                row_end
);
  logic [COL_BITS-1:0] col_q, col_n;

  always_comb begin
    col_n = col_q;
    if (load)     col_n = load_col;
    else if (inc) col_n = col_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_q <= '0;
    else        col_q <= col_n;
  end

  assign col     = col_q;
  assign row_end = &col_q;

  // R4: an advance moves exactly one column, wrapping at the row end
  p_col_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> (col_q == COL_BITS'($past(col_q) + 1'b1)));
endmodule

// File: rtl/psram_wait_gen.sv
module psram_wait_gen
  import psram_wait_pkg::*;
#(
  parameter int LATENCY          = 3,
  parameter int COL_BITS         = 7,
  parameter int ROW_STALL        = 1,
  parameter bit WAIT_ACTIVE_HIGH = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                addr_lat_n,
  input  logic                wr_en,
  input  logic [COL_BITS-1:0] addr_col,
  input  logic                cfg_sync_burst,
  input  logic                cfg_fixed_lat,
  input  logic                refresh_busy,
  output logic                stall_o,
  output logic                beat_vld_o,
  output logic [COL_BITS-1:0] beat_col_o
);
  localparam int CTR_MAX = (LATENCY > ROW_STALL) ? LATENCY : ROW_STALL;
  localparam int CTR_W   = $clog2(CTR_MAX + 1);
  localparam logic [CTR_W-1:0] LAT_LOAD   = CTR_W'(LATENCY - 1);
  localparam logic [CTR_W-1:0] STALL_LOAD = CTR_W'(ROW_STALL - 1);

  logic srst_n;
  phase_e phase_q, phase_n;
  logic stall_q, stall_n, vld_q, vld_n, coll_q, coll_n;
  logic ctr_load, ctr_dec, ctr_zero;
  logic [CTR_W-1:0] ctr_val;
  logic col_load, col_inc, row_end;
  logic [COL_BITS-1:0] col;

  psram_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  psram_dwell_ctr #(.W(CTR_W)) u_dwell (
    .clk(clk), .rst_n(srst_n), .load(ctr_load), .load_val(ctr_val),
    .dec(ctr_dec), .expired(ctr_zero)
  );

  psram_col_tracker #(.COL_BITS(COL_BITS)) u_col (
    .clk(clk), .rst_n(srst_n), .load(col_load), .load_col(addr_col),
    .inc(col_inc), .col(col), .row_end(row_end)
  );

  always_comb begin
    phase_n  = phase_q;
    stall_n  = stall_q;
    vld_n    = 1'b0;
    coll_n   = coll_q;
    ctr_load = 1'b0;
    ctr_val  = LAT_LOAD;
    ctr_dec  = 1'b0;
    col_load = 1'b0;
    col_inc  = 1'b0;
    if (cs_n) begin
      phase_n = PH_IDLE;
      stall_n = 1'b0;
      coll_n  = 1'b0;
    end else if (!cfg_sync_burst) begin
      phase_n = PH_IDLE;
      stall_n = 1'b1;
      coll_n  = 1'b0;
    end else if (!addr_lat_n) begin
      phase_n  = PH_LATENCY;
      stall_n  = 1'b1;
      ctr_load = 1'b1;
      col_load = 1'b1;
      coll_n   = !cfg_fixed_lat && !wr_en && refresh_busy;
    end else begin
      case (phase_q)
        PH_IDLE: stall_n = 1'b0;
        PH_LATENCY: begin
          stall_n = 1'b1;
          if (!(coll_q && refresh_busy)) begin
            coll_n = 1'b0;
            if (ctr_zero) begin
              phase_n = PH_BEAT;
              stall_n = 1'b0;
              vld_n   = 1'b1;
            end else begin
              ctr_dec = 1'b1;
            end
          end
        end
        PH_BEAT: begin
          col_inc = 1'b1;
          if (row_end) begin
            phase_n  = PH_ROWSTALL;
            stall_n  = 1'b1;
            ctr_load = 1'b1;
            ctr_val  = STALL_LOAD;
          end else begin
            stall_n = 1'b0;
            vld_n   = 1'b1;
          end
        end
        PH_ROWSTALL: begin
          stall_n = 1'b1;
          if (ctr_zero) begin
            phase_n = PH_BEAT;
            stall_n = 1'b0;
            vld_n   = 1'b1;
          end else begin
            ctr_dec = 1'b1;
          end
        end
        default: phase_n = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      phase_q <= PH_IDLE;
      stall_q <= 1'b0;
      vld_q   <= 1'b0;
      coll_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      stall_q <= stall_n;
      vld_q   <= vld_n;
      coll_q  <= coll_n;
    end
  end

  assign stall_o    = WAIT_ACTIVE_HIGH ? stall_q : ~stall_q;
  assign beat_vld_o = vld_q;
  assign beat_col_o = col;

  // R2: a strobe in burst mode raises the stall and suppresses beats
  p_start_stalls_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (!cs_n && !addr_lat_n && cfg_sync_burst) |=> (stall_q && !vld_q));
  // R5: a colliding read holds its latency while the refresh stays busy
  p_coll_hold_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (phase_q == PH_LATENCY && coll_q && refresh_busy && !cs_n && addr_lat_n
     && cfg_sync_burst) |=> (phase_q == PH_LATENCY && stall_q));
  // R6: fixed latency never records a collision
  p_fixed_no_coll_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (!cs_n && !addr_lat_n && cfg_sync_burst && cfg_fixed_lat) |=> !coll_q);
  // R8: the beat on the last column is followed by a stall and a wrap
  p_row_stall_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (vld_q && row_end && !cs_n && addr_lat_n && cfg_sync_burst)
    |=> (stall_q && !vld_q && col == '0));
  // R9: asynchronous operation never produces beats
  p_async_quiet_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (!cs_n && !cfg_sync_burst) |=> (stall_q && !vld_q));
  // R10: deselect releases the stall and idles
  p_deselect_idle_r10: assert property (@(posedge clk) disable iff (!srst_n)
    cs_n |=> (!stall_q && !vld_q && phase_q == PH_IDLE));
endmodule

// File: tb/psram_wait_gen_bench.sv
module psram_wait_gen_bench;
  localparam int LAT  = 3;
  localparam int CB   = 3;
  localparam int RST  = 2;
  localparam bit ACTH = 1'b0;
  localparam int NCOL = 1 << CB;

  typedef struct packed {
    logic          act;
    logic          vld;
    logic [CB-1:0] col;
    logic [7:0]    req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n, cs_n, addr_lat_n, wr_en, cfg_sync_burst, cfg_fixed_lat, refresh_busy;
  logic [CB-1:0] addr_col;
  logic stall_o, beat_vld_o;
  logic [CB-1:0] beat_col_o;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int wd = 0;

  always #10 clk = ~clk;

  psram_wait_gen #(.LATENCY(LAT), .COL_BITS(CB), .ROW_STALL(RST),
                   .WAIT_ACTIVE_HIGH(ACTH)) u_psram_wait_gen (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr_lat_n(addr_lat_n),
    .wr_en(wr_en), .addr_col(addr_col), .cfg_sync_burst(cfg_sync_burst),
    .cfg_fixed_lat(cfg_fixed_lat), .refresh_busy(refresh_busy),
    .stall_o(stall_o), .beat_vld_o(beat_vld_o), .beat_col_o(beat_col_o)
  );

  function automatic logic lvl(input logic act);
    return act ? ACTH : ~ACTH;
  endfunction

  // monitor: pops one expected item per edge, a quarter period after it
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (stall_o !== lvl(e.act) || beat_vld_o !== e.vld ||
          (e.vld && beat_col_o !== e.col)) begin
        errors++;
        $display("FAIL R%0d: stall=%b vld=%b col=%0d expected stall=%b vld=%b col=%0d",
                 e.req, stall_o, beat_vld_o, beat_col_o, lvl(e.act), e.vld, e.col);
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd == 20000) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected end before 20000 cycles");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // driver: applies inputs for the next edge and queues the expected result
  task automatic drive(input logic cs, input logic strobe, input logic wr,
                       input logic rb, input logic [CB-1:0] a,
                       input logic act, input logic vld,
                       input logic [CB-1:0] col, input int req);
    exp_t e;
    cs_n = cs; addr_lat_n = strobe; wr_en = wr; refresh_busy = rb; addr_col = a;
    e.act = act; e.vld = vld; e.col = col; e.req = 8'(req);
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  // one burst: rb0 = refresh at start edge, hold = later edges with refresh high
  task automatic burst(input logic [CB-1:0] a, input logic wr, input logic rb0,
                       input int hold, input int nbeats, input bit release_cs,
                       input int req);
    int ext;
    int k;
    int n;
    logic [CB-1:0] c;
    ext = (!cfg_fixed_lat && !wr && rb0) ? hold : 0;
    drive(1'b0, 1'b0, wr, rb0, a, 1'b1, 1'b0, '0, 2);          // R2
    k = 1;
    for (int i = 1; i < LAT + ext; i++) begin
      drive(1'b0, 1'b1, wr, k <= hold, a, 1'b1, 1'b0, '0, req);
      k++;
    end
    c = a;
    n = 0;
    while (n < nbeats) begin
      drive(1'b0, 1'b1, wr, k <= hold, a, 1'b0, 1'b1, c, (n == 0) ? req : 4);  // R3 / R4
      k++;
      n++;
      if (c == CB'(NCOL - 1)) begin
        for (int s = 0; s < RST; s++) drive(1'b0, 1'b1, wr, 1'b0, a, 1'b1, 1'b0, '0, 8);  // R8
        c = '0;
      end else begin
        c = c + 1'b1;
      end
    end
    if (release_cs) drive(1'b1, 1'b1, wr, 1'b0, a, 1'b0, 1'b0, '0, 10);  // R10
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; addr_lat_n = 1'b1; wr_en = 1'b0; addr_col = '0;
    cfg_sync_burst = 1'b1; cfg_fixed_lat = 1'b0; refresh_busy = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset levels while reset is held
    checks++;
    if (stall_o !== lvl(1'b0) || beat_vld_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: stall=%b vld=%b expected stall=%b vld=0", stall_o, beat_vld_o, lvl(1'b0));
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11: inactive level of an active-low build is 1, selected but idle
    drive(1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0, 11);
    drive(1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0, 1);      // R1

    burst(3'd2, 1'b0, 1'b0, 0, 3, 1'b1, 3);    // R3 plain read, R4 beats
    burst(3'd6, 1'b0, 1'b0, 0, 5, 1'b1, 8);    // R8 row crossing 6,7,stall,0,1,2
    burst(3'd7, 1'b1, 1'b0, 0, 2, 1'b1, 8);    // R8 start on last column (write)
    burst(3'd1, 1'b0, 1'b1, 4, 2, 1'b1, 5);    // R5 collision adds four cycles
    burst(3'd3, 1'b0, 1'b0, 2, 2, 1'b1, 5);    // R5 refresh rising late adds nothing
    burst(3'd5, 1'b1, 1'b1, 4, 2, 1'b1, 7);    // R7 write ignores refresh
    cfg_fixed_lat = 1'b1;
    burst(3'd0, 1'b0, 1'b1, 4, 2, 1'b1, 6);    // R6 fixed latency ignores refresh
    cfg_fixed_lat = 1'b0;

    // R12: strobe in the middle of beats restarts at the new column
    burst(3'd2, 1'b0, 1'b0, 0, 2, 1'b0, 12);
    burst(3'd5, 1'b0, 1'b0, 0, 4, 1'b1, 12);
    // R12: strobe during latency restarts the count
    drive(1'b0, 1'b0, 1'b0, 1'b0, 3'd4, 1'b1, 1'b0, '0, 12);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 3'd4, 1'b1, 1'b0, '0, 12);
    burst(3'd1, 1'b0, 1'b0, 0, 1, 1'b1, 12);

    // R10: deselect during latency, then selected without strobe stays idle
    drive(1'b0, 1'b0, 1'b0, 1'b0, 3'd4, 1'b1, 1'b0, '0, 2);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 3'd4, 1'b1, 1'b0, '0, 2);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 3'd4, 1'b0, 1'b0, '0, 10);
    for (int i = 0; i < 4; i++) drive(1'b0, 1'b1, 1'b0, 1'b0, 3'd4, 1'b0, 1'b0, '0, 10);

    // R9: asynchronous operation, strobes ignored, no beats
    cfg_sync_burst = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 1'b1, 1'b0, '0, 9);
    for (int i = 0; i < 5; i++) drive(1'b0, i[0], 1'b0, i[1], 3'd3, 1'b1, 1'b0, '0, 9);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, '0, 10);
    cfg_sync_burst = 1'b1;
    drive(1'b1, 1'b1, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, '0, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule